// File: doc/BRIEF.md
# Auxiliary Channel Request Controller

This block is the register-side front end of a display auxiliary-channel transceiver. Software sees one 32-bit control/status register and a buffer of 32-bit data registers on a small register bus. It loads a request of up to 20 bytes into the buffer. It then writes the control register with the length, the timeout choice and the start bit set. The block hands the request to a transaction engine through a one-cycle request pulse. It waits for the engine's reply or for a timeout counted in microsecond ticks. It then reports completion, error flags and the reply length, and stores the reply bytes back into the same buffer.

The start bit also serves as the busy flag. The three status flags are write-one-to-clear, so the write that launches a transfer can clear the previous result. The size field carries the request length outbound and the reply length inbound. The line encoding is not part of this block. A request/reply handshake port takes its place.

Top module: `aux_req_ctrl`

## Requirements
- R1: After a synchronous reset the control word reads 0, every data register reads 0, and `irq` and `req_valid` are 0.
- R2: A control write (address 0) with bit 31 set while idle makes bit 31 read 1. In the next cycle `req_valid` is high for exactly one cycle. At that point `req_len` equals the size field (bits 24:20), `req_precharge` equals bits 19:16, `req_clkdiv` equals bits 10:0, and `req_data` carries buffer byte i at bits 8i+7:8i.
- R3: Data register k (address 1+k, k = 0..4) holds buffer bytes 4k..4k+3, with byte 4k in bits 31:24 and the following bytes in descending lanes.
- R4: Writing 1 to bit 30 (done), bit 28 (timeout error) or bit 25 (receive error) clears that flag. This also works in the same write that sets bit 31. Writing 0 to them changes nothing.
- R5: While bit 31 reads 1, control and data writes have no effect.
- R6: A reply (`rsp_valid`) while busy clears bit 31 and sets done. The size field becomes `rsp_len`, bytes i < `rsp_len` are replaced by reply byte i, and the other bytes keep their values.
- R7: Bits 27:26 select the timeout: 0 = 400, 1 = 600, 2 = 800, 3 = 1600 ticks of `us_tick`. With no reply, the tick that reaches the limit sets the timeout error and done, clears busy and sets the size field to 0. Without ticks, no timeout occurs.
- R8: A reply with `rsp_err` set or with `rsp_len` above 20 sets the receive error and done, sets the size field to 0, and leaves the buffer unchanged. A reply of length 0 gives size 0 with no error flag.
- R9: `irq` is 1 exactly while the interrupt enable (bit 29) and done are both 1.
- R10: `rsp_valid` while idle is ignored. A reply in the same cycle as the expiring tick counts as a reply and not as a timeout.
- R11: `bus_rdata` shows, one cycle later, the register addressed in the previous cycle. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 control, 1..5 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| us_tick | input | 1 | One-cycle microsecond tick |
| req_valid | output | 1 | One-cycle request launch pulse |
| req_len | output | 5 | Request length in bytes |
| req_data | output | 160 | Request bytes, byte i at bits 8i+7:8i |
| req_precharge | output | 4 | Precharge-time setting |
| req_clkdiv | output | 11 | Double-bit-clock divider |
| rsp_valid | input | 1 | Reply present (one cycle) |
| rsp_err | input | 1 | Engine detected a receive error |
| rsp_len | input | 6 | Reply length in bytes |
| rsp_data | input | 160 | Reply bytes, byte i at bits 8i+7:8i |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions watch, on every cycle, that each rise of busy comes with a single-cycle launch pulse and that busy only falls with done set. They also check that a rising timeout or receive error leaves the size field at 0, that `irq` follows enable and done, and that the configuration fields hold still during a transfer. Only the bench scenarios can show the exact tick count of each timeout code, the per-byte partial overwrite on a reply, the byte lane order, and the tie between a reply and the expiring tick. A behavioural model compared on every clock covers the read path and the launch outputs.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  localparam int BUSY_B  = 31;
  localparam int DONE_B  = 30;
  localparam int IE_B    = 29;
  localparam int TOERR_B = 28;
  localparam int TSEL_LO = 26;
  localparam int RXERR_B = 25;
  localparam int SIZE_LO = 20;
  localparam int PRE_LO  = 16;
  localparam int SIZE_W  = 5;
  localparam int PRE_W   = 4;
  localparam int DIV_W   = 11;
  localparam int TSEL_W  = 2;

  typedef struct packed {
    logic              busy;
    logic              done;
    logic              ie;
    logic              to_err;
    logic [TSEL_W-1:0] tsel;
    logic              rx_err;
    logic [SIZE_W-1:0] size;
    logic [PRE_W-1:0]  pre;
    logic [DIV_W-1:0]  div;
  } ctrl_t;

  function automatic logic [31:0] ctrl_word(ctrl_t c);
    return {c.busy, c.done, c.ie, c.to_err, c.tsel, c.rx_err, c.size, c.pre, 5'b0, c.div};
  endfunction
endpackage

// File: rtl/aux_timeout.sv
module aux_timeout #(
  parameter int T0 = 400,
  parameter int T1 = 600,
  parameter int T2 = 800,
  parameter int T3 = 1600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int M01  = (T0 > T1) ? T0 : T1;
  localparam int M23  = (T2 > T3) ? T2 : T3;
  localparam int MAXT = (M01 > M23) ? M01 : M23;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    case (sel)
      2'd0:    lim = CW'(T0);
      2'd1:    lim = CW'(T1);
      2'd2:    lim = CW'(T2);
      default: lim = CW'(T3);
    endcase
  end

  assign expire = run && tick && (cnt_q == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || start) cnt_q <= '0;
    else if (run && tick) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/aux_byte_pack.sv
module aux_byte_pack #(
  parameter int NB = 20,
  parameter int NW = (NB + 3) / 4
) (
  input  logic [8*NB-1:0] bytes_i,
  output logic [32*NW-1:0] words_o
);
  for (genvar w = 0; w < NW; w++) begin : g_word
    for (genvar l = 0; l < 4; l++) begin : g_lane
      if (4*w + l < NB) begin : g_used
        assign words_o[32*w + 8*(3-l) +: 8] = bytes_i[8*(4*w+l) +: 8];
      end else begin : g_pad
        assign words_o[32*w + 8*(3-l) +: 8] = 8'h00;
      end
    end
  end
endmodule

// File: rtl/aux_req_ctrl.sv
module aux_req_ctrl
  import aux_req_pkg::*;
#(
  parameter int NBYTES = 20,
  parameter int AW     = 3,
  parameter int RLEN_W = 6,
  parameter int TO_0   = 400,
  parameter int TO_1   = 600,
  parameter int TO_2   = 800,
  parameter int TO_3   = 1600
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                us_tick,
  output logic                req_valid,
  output logic [SIZE_W-1:0]   req_len,
  output logic [8*NBYTES-1:0] req_data,
  output logic [PRE_W-1:0]    req_precharge,
  output logic [DIV_W-1:0]    req_clkdiv,
  input  logic                rsp_valid,
  input  logic                rsp_err,
  input  logic [RLEN_W-1:0]   rsp_len,
  input  logic [8*NBYTES-1:0] rsp_data,
  output logic                irq
);
  localparam int NWORDS = (NBYTES + 3) / 4;
  localparam logic [RLEN_W-1:0] NB_L = RLEN_W'(NBYTES);

  ctrl_t ctl_q, ctl_d;
  logic [7:0] dbuf [NBYTES];
  logic [8*NBYTES-1:0] byte_flat;
  logic [32*NWORDS-1:0] word_flat;
  logic start, accept, bad, fill, expire, ctl_wr, dat_wr;
  logic [31:0] rd_word;

  assign ctl_wr = !ctl_q.busy && bus_wr && (bus_addr == '0);
  assign dat_wr = !ctl_q.busy && bus_wr;
  assign start  = ctl_wr && bus_wdata[BUSY_B];
  assign accept = ctl_q.busy && rsp_valid;
  assign bad    = rsp_err || (rsp_len > NB_L);
  assign fill   = accept && !bad;

  aux_timeout #(.T0(TO_0), .T1(TO_1), .T2(TO_2), .T3(TO_3)) u_tmo (
    .clk(clk), .rst(rst), .start(start), .run(ctl_q.busy),
    .tick(us_tick), .sel(ctl_q.tsel), .expire(expire)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_q.busy) begin
      if (accept) begin
        ctl_d.busy = 1'b0;
        ctl_d.done = 1'b1;
        if (bad) begin
          ctl_d.rx_err = 1'b1;
          ctl_d.size   = '0;
        end else begin
          ctl_d.size = rsp_len[SIZE_W-1:0];
        end
      end else if (expire) begin
        ctl_d.busy   = 1'b0;
        ctl_d.done   = 1'b1;
        ctl_d.to_err = 1'b1;
        ctl_d.size   = '0;
      end
    end else if (ctl_wr) begin
      ctl_d.busy   = bus_wdata[BUSY_B];
      ctl_d.done   = ctl_q.done   && !bus_wdata[DONE_B];
      ctl_d.to_err = ctl_q.to_err && !bus_wdata[TOERR_B];
      ctl_d.rx_err = ctl_q.rx_err && !bus_wdata[RXERR_B];
      ctl_d.ie     = bus_wdata[IE_B];
      ctl_d.tsel   = bus_wdata[TSEL_LO +: TSEL_W];
      ctl_d.size   = bus_wdata[SIZE_LO +: SIZE_W];
      ctl_d.pre    = bus_wdata[PRE_LO +: PRE_W];
      ctl_d.div    = bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      req_valid <= 1'b0;
      irq       <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      req_valid <= start;
      irq       <= ctl_d.ie && ctl_d.done;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int WSEL = i / 4 + 1;
    localparam int LANE = 3 - (i % 4);
    always_ff @(posedge clk) begin
      if (rst) dbuf[i] <= 8'h00;
      else if (dat_wr && int'(bus_addr) == WSEL) dbuf[i] <= bus_wdata[8*LANE +: 8];
      else if (fill && RLEN_W'(i) < rsp_len) dbuf[i] <= rsp_data[8*i +: 8];
    end
    assign byte_flat[8*i +: 8] = dbuf[i];
  end

  aux_byte_pack #(.NB(NBYTES), .NW(NWORDS)) u_pack (
    .bytes_i(byte_flat), .words_o(word_flat)
  );

  always_comb begin
    rd_word = '0;
    if (bus_addr == '0) rd_word = ctrl_word(ctl_q);
    for (int k = 0; k < NWORDS; k++)
      if (int'(bus_addr) == k + 1) rd_word = word_flat[32*k +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_word;
  end

  assign req_data      = byte_flat;
  assign req_len       = ctl_q.size;
  assign req_precharge = ctl_q.pre;
  assign req_clkdiv    = ctl_q.div;
endmodule

// File: rtl/aux_req_chk.sv
module aux_req_chk
  import aux_req_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input ctrl_t ctl,
  input logic  req_valid,
  input logic  irq
);
  // R2
  launch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.busy) |-> req_valid);
  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
  // R6
  end_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl.busy) |-> ctl.done);
  // R7
  timeout_size_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.to_err) |-> (ctl.size == '0) && !ctl.busy && ctl.done);
  // R8
  rxerr_size_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.rx_err) |-> (ctl.size == '0) && ctl.done);
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ctl.ie && ctl.done));
  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.busy && $past(ctl.busy)) |-> ($stable(ctl.pre) && $stable(ctl.div) &&
                                       $stable(ctl.tsel) && $stable(ctl.ie)));
endmodule

bind aux_req_ctrl aux_req_chk u_chk (
  .clk(clk), .rst(rst), .ctl(ctl_q), .req_valid(req_valid), .irq(irq)
);

// File: tb/test_aux_req_ctrl.sv
module test_aux_req_ctrl;
  logic clk = 0, rst = 1, bus_wr = 0, us_tick = 1;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic req_valid, irq, rsp_valid = 0, rsp_err = 0;
  logic [4:0] req_len;
  logic [159:0] req_data, rsp_data;
  logic [3:0] req_precharge;
  logic [10:0] req_clkdiv;
  logic [5:0] rsp_len = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  aux_req_ctrl i_aux_req_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .us_tick(us_tick), .req_valid(req_valid), .req_len(req_len),
    .req_data(req_data), .req_precharge(req_precharge), .req_clkdiv(req_clkdiv),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_len(rsp_len), .rsp_data(rsp_data),
    .irq(irq)
  );

  // reference model state
  bit m_busy, m_done, m_ie, m_to, m_rx, m_reqv, m_irq;
  int m_tsel, m_size, m_pre, m_div, m_cnt;
  logic [7:0] mbuf [20];
  logic [31:0] m_rd;

  function automatic logic [31:0] m_read(int a);
    if (a == 0)
      return {m_busy, m_done, m_ie, m_to, 2'(m_tsel), m_rx, 5'(m_size), 4'(m_pre), 5'b0, 11'(m_div)};
    if (a >= 1 && a <= 5)
      return {mbuf[4*a-4], mbuf[4*a-3], mbuf[4*a-2], mbuf[4*a-1]};
    return 32'h0;
  endfunction

  function automatic int lim_of(int s);
    case (s)
      0: return 400;
      1: return 600;
      2: return 800;
      default: return 1600;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_ie = 0; m_to = 0; m_rx = 0; m_reqv = 0; m_irq = 0;
      m_tsel = 0; m_size = 0; m_pre = 0; m_div = 0; m_cnt = 0; m_rd = 0;
      foreach (mbuf[i]) mbuf[i] = 0;
    end else begin
      m_rd = m_read(int'(bus_addr));
      m_reqv = 0;
      if (m_busy) begin
        if (rsp_valid) begin
          m_busy = 0; m_done = 1;
          if (rsp_err || rsp_len > 20) begin m_rx = 1; m_size = 0; end
          else begin
            m_size = rsp_len;
            for (int i = 0; i < rsp_len; i++) mbuf[i] = rsp_data[8*i +: 8];
          end
        end else if (us_tick) begin
          if (m_cnt + 1 == lim_of(m_tsel)) begin
            m_busy = 0; m_done = 1; m_to = 1; m_size = 0;
          end else m_cnt++;
        end
      end else if (bus_wr) begin
        if (bus_addr == 0) begin
          if (bus_wdata[30]) m_done = 0;
          if (bus_wdata[28]) m_to = 0;
          if (bus_wdata[25]) m_rx = 0;
          m_ie = bus_wdata[29]; m_tsel = bus_wdata[27:26]; m_size = bus_wdata[24:20];
          m_pre = bus_wdata[19:16]; m_div = bus_wdata[10:0];
          if (bus_wdata[31]) begin m_busy = 1; m_reqv = 1; m_cnt = 0; end
        end else if (bus_addr <= 5) begin
          for (int l = 0; l < 4; l++) mbuf[4*(bus_addr-1)+l] = bus_wdata[8*(3-l) +: 8];
        end
      end
      m_irq = m_ie && m_done;
    end
  end

  task automatic check(string tag, logic [159:0] got, logic [159:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R11 per-cycle rdata", {128'b0, bus_rdata}, {128'b0, m_rd});
      check("R9 per-cycle irq", {159'b0, irq}, {159'b0, m_irq});
      check("R2 per-cycle req_valid", {159'b0, req_valid}, {159'b0, m_reqv});
      check("R2 per-cycle precharge/div", {145'b0, req_precharge, req_clkdiv},
            {145'b0, 4'(m_pre), 11'(m_div)});
      if (m_reqv) begin
        logic [159:0] e;
        for (int i = 0; i < 20; i++) e[8*i +: 8] = mbuf[i];
        check("R2 per-cycle req_len", {155'b0, req_len}, {155'b0, 5'(m_size)});
        check("R2 per-cycle req_data", req_data, e);
      end
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); bus_addr = 3'(a);
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic rd_chk(string tag, int a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, {128'b0, v}, {128'b0, exp});
  endtask

  task automatic reply(int len, bit err);
    @(negedge clk); rsp_valid = 1; rsp_len = 6'(len); rsp_err = err;
    @(negedge clk); rsp_valid = 0; rsp_err = 0;
  endtask

  task automatic poll(output int n);
    bus_addr = 0; n = 0;
    do begin @(negedge clk); n++; end while (bus_rdata[31] && n < 5000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    for (int i = 0; i < 20; i++) rsp_data[8*i +: 8] = 8'hA0 + 8'(i);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_chk("R1 ctrl after reset", 0, 32'h0);
    for (int k = 1; k <= 5; k++) rd_chk("R1 data after reset", k, 32'h0);
    check("R1 irq/req_valid", {158'b0, irq, req_valid}, 160'b0);
    // R3 packing
    for (int k = 0; k < 5; k++)
      wr(k + 1, {8'h10 + 8'(4*k), 8'h11 + 8'(4*k), 8'h12 + 8'(4*k), 8'h13 + 8'(4*k)});
    rd_chk("R3 data reg lane order", 3, 32'h18191A1B);
    // R2 launch
    wr(0, 32'hA45A0123);
    check("R2 req_valid pulse", {159'b0, req_valid}, 160'd1);
    check("R2 req_len", {155'b0, req_len}, 160'd5);
    check("R2 req byte0", {152'b0, req_data[7:0]}, 160'h10);
    check("R2 req byte13", {152'b0, req_data[111:104]}, 160'h1D);
    check("R2 precharge/div", {145'b0, req_precharge, req_clkdiv}, {145'b0, 4'hA, 11'h123});
    @(negedge clk);
    check("R2 pulse ends", {159'b0, req_valid}, 160'd0);
    rd_chk("R2 busy reads 1", 0, 32'hA45A0123);
    // R5 writes ignored while busy
    wr(0, 32'h0);
    wr(2, 32'hFFFFFFFF);
    rd_chk("R5 ctrl unchanged", 0, 32'hA45A0123);
    rd_chk("R5 data unchanged", 2, 32'h14151617);
    // R6 reply of 7 bytes
    reply(7, 0);
    rd_chk("R6 ctrl after reply", 0, 32'h647A0123);
    rd_chk("R6 bytes 0..3", 1, 32'hA0A1A2A3);
    rd_chk("R6 partial word", 2, 32'hA4A5A617);
    check("R9 irq with ie and done", {159'b0, irq}, 160'd1);
    // R4 clear done
    wr(0, 32'h40000000);
    rd_chk("R4 done cleared", 0, 32'h0);
    check("R9 irq low after clear", {159'b0, irq}, 160'd0);
    // R7 timeout code 0
    wr(0, 32'h80300000);
    poll(n);
    check("R7 400-tick timeout", 160'(n), 160'd401);
    rd_chk("R7 timeout flags", 0, 32'h50000000);
    // R4 clear in the start write
    wr(0, 32'hDC400000);
    rd_chk("R4 cleared with start", 0, 32'h8C400000);
    reply(2, 0);
    // R7 code 3
    wr(0, 32'hCC400000);
    poll(n);
    check("R7 1600-tick timeout", 160'(n), 160'd1601);
    rd_chk("R7 code 3 flags", 0, 32'h5C000000);
    // R7 code 2
    wr(0, 32'hD8100000);
    poll(n);
    check("R7 800-tick timeout", 160'(n), 160'd801);
    // R8 overlong reply
    wr(0, 32'hD6300000);
    reply(25, 0);
    rd_chk("R8 overlong sets rx err", 0, 32'h46000000);
    rd_chk("R8 data kept", 1, 32'hA0A1A2A3);
    wr(0, 32'hD6300000);
    reply(4, 1);
    rd_chk("R8 engine error", 0, 32'h46000000);
    wr(0, 32'hD6300000);
    reply(0, 0);
    rd_chk("R8 zero length", 0, 32'h44000000);
    // R10 idle reply ignored
    rsp_data[7:0] = 8'h55;
    reply(9, 0);
    rd_chk("R10 idle reply ignored ctrl", 0, 32'h44000000);
    rd_chk("R10 idle reply ignored data", 1, 32'hA0A1A2A3);
    // R10 reply on the expiring tick
    wr(0, 32'hC0100000);
    repeat (399) @(negedge clk);
    rsp_valid = 1; rsp_len = 6; @(negedge clk); rsp_valid = 0;
    rd_chk("R10 reply wins tie", 0, 32'h40600000);
    rd_chk("R6 new byte0", 1, 32'h55A1A2A3);
    // R7 no ticks, no timeout
    us_tick = 0;
    wr(0, 32'hC0100000);
    repeat (1000) @(negedge clk);
    rd_chk("R7 no tick stays busy", 0, 32'h80100000);
    reply(1, 0);
    us_tick = 1;
    rd_chk("R6 one byte reply", 0, 32'h40100000);
    // R11 unused addresses
    rd_chk("R11 addr 6", 6, 32'h0);
    rd_chk("R11 addr 7", 7, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule